// File: doc/BRIEF.md
# Serial Memory Word Address Counter with Page and Array Wrap

This block keeps the current byte address of a 512-byte two-wire serial EEPROM. The bus front end loads it when a transfer sets a new location. One high address bit comes from the device-select byte and eight low bits come from the word-address byte. After each byte moves, the front end pulses an increment strobe. That strobe is tagged with the direction of the transfer.

The two directions wrap in different ways. A write step advances only the byte offset inside the current 16-byte page, so a long burst of writes cycles inside one page. A read step advances the whole address, crosses page edges, and wraps from the top of the array back to zero. Between transactions the counter holds its value. A later current-address read therefore starts at the location after the last byte touched.

All pins are plain control strobes that take effect on the clock edge that samples them. There is no data stream and no handshake, so no back-pressure applies. The front end reads `addr_o` to fetch the byte for transmission and pulses the read increment only after that fetch.

Top module: `acw_addr_counter`

## Requirements
- R1: While `rst_n` is low the counter is forced to address 0, and `addr_o` reads 0 in the cycle after reset is seen.
- R2: A cycle with `load_i` high sets `addr_o`, from the next cycle, to `{load_hi_i, load_lo_i}`. `load_hi_i` becomes address bit 8 and `load_lo_i` becomes bits 7:0.
- R3: A write step (`inc_i` high, `inc_rd_i` low, `load_i` low) adds one to bits 3:0 modulo 16 and leaves bits 8:4 unchanged, so 0x1AF becomes 0x1A0 and 0x1FF becomes 0x1F0.
- R4: A read step (`inc_i` high, `inc_rd_i` high, `load_i` low) adds one to the full 9-bit address modulo 512, so 0x0FF becomes 0x100 and 0x1FF becomes 0x000.
- R5: With `load_i` and `inc_i` both low the address holds indefinitely. A later read step continues from the held value.
- R6: When `load_i` and `inc_i` are high in the same cycle the load wins and no step is applied.
- R7: Every strobe cycle is acted on independently, so back-to-back strobes give one update each. The result appears on `addr_o` one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe for a new address |
| load_hi_i | input | 1 | Page-select bit from the device-select byte (address bit 8) |
| load_lo_i | input | 8 | Word-address byte (address bits 7:0) |
| inc_i | input | 1 | Step strobe, one pulse per transferred byte |
| inc_rd_i | input | 1 | Direction of the step: 1 for read (array wrap), 0 for write (page wrap) |
| addr_o | output | 9 | Current word address |

## Verification
The bench builds the block with its default parameters: a 9-bit address, an 8-bit word-address byte and 16-byte pages. With these values the page wrap is reached after 16 write steps and the array wrap is reached after one read step from 0x1FF, so both wrap points fit in short directed runs. The same values also keep a long mixed random run inside a small budget.

// File: rtl/acw_pkg.sv
package acw_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_LOAD  = 2'd1,
    STEP_PAGE  = 2'd2,
    STEP_ARRAY = 2'd3
  } step_e;
endpackage

// File: rtl/acw_incr.sv
// Increment that wraps inside the low WRAP_W bits; a full-width
// variant is chosen when WRAP_W covers the whole address.
module acw_incr #(
  parameter int W      = 9,
  parameter int WRAP_W = 4
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  generate
    if (WRAP_W >= W) begin : g_full
      assign nxt_o = cur_i + W'(1);
    end else begin : g_part
      assign nxt_o = {cur_i[W-1:WRAP_W], cur_i[WRAP_W-1:0] + WRAP_W'(1)};
    end
  endgenerate
endmodule

// File: rtl/acw_sel.sv
// Strobe decode with load priority.
module acw_sel
  import acw_pkg::*;
(
  input  logic  load_i,
  input  logic  inc_i,
  input  logic  inc_rd_i,
  output step_e step_o
);
  always_comb begin
    if (load_i)        step_o = STEP_LOAD;
    else if (!inc_i)   step_o = STEP_HOLD;
    else if (inc_rd_i) step_o = STEP_ARRAY;
    else               step_o = STEP_PAGE;
  end
endmodule

// File: rtl/acw_addr_counter.sv
module acw_addr_counter
  import acw_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BYTE_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-BYTE_W-1:0] load_hi_i,
  input  logic [BYTE_W-1:0] load_lo_i,
  input  logic              inc_i,
  input  logic              inc_rd_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - BYTE_W;

  step_e             step;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] page_nxt;
  logic [ADDR_W-1:0] array_nxt;
  logic [ADDR_W-1:0] addr_d;

  acw_sel i_sel (
    .load_i   (load_i),
    .inc_i    (inc_i),
    .inc_rd_i (inc_rd_i),
    .step_o   (step)
  );

  acw_incr #(.W(ADDR_W), .WRAP_W(PAGE_W)) i_page_incr (
    .cur_i (addr_q),
    .nxt_o (page_nxt)
  );

  acw_incr #(.W(ADDR_W), .WRAP_W(ADDR_W)) i_array_incr (
    .cur_i (addr_q),
    .nxt_o (array_nxt)
  );

  always_comb begin
    unique case (step)
      STEP_LOAD:  addr_d = {load_hi_i, load_lo_i};
      STEP_PAGE:  addr_d = page_nxt;
      STEP_ARRAY: addr_d = array_nxt;
      default:    addr_d = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // Assertions next to the register they guard.
  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |=> (addr_o == '0));

  a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past({load_hi_i, load_lo_i})));

  a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && inc_i && !inc_rd_i) |=>
      (addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W])));

  a_r3_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && inc_i && !inc_rd_i) |=>
      (addr_o[PAGE_W-1:0] == PAGE_W'($past(addr_o[PAGE_W-1:0]) + 1'b1)));

  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && inc_i && inc_rd_i) |=>
      (addr_o == ADDR_W'($past(addr_o) + 1'b1)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !inc_i) |=> $stable(addr_o));

  initial begin
    a_r2_width_ok: assert (HI_W >= 1 && PAGE_W < ADDR_W);
  end
endmodule

// File: tb/test_acw_addr_counter.sv
module test_acw_addr_counter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int SPAN = 512;
  localparam int PAGE = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_i;
  logic [0:0] load_hi_i;
  logic [7:0] load_lo_i;
  logic       inc_i;
  logic       inc_rd_i;
  logic [AW-1:0] addr_o;

  int compared = 0;
  int mismatched = 0;
  int exp_addr = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acw_addr_counter i_acw_addr_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .load_hi_i (load_hi_i),
    .load_lo_i (load_lo_i),
    .inc_i     (inc_i),
    .inc_rd_i  (inc_rd_i),
    .addr_o    (addr_o)
  );

  // Drive at a falling edge, update the model at the rising edge,
  // compare shortly after it.
  task automatic step(input logic ld, input logic hi, input logic [7:0] lo,
                      input logic inc, input logic rd, input string tag);
    load_i = ld; load_hi_i = hi; load_lo_i = lo; inc_i = inc; inc_rd_i = rd;
    @(posedge clk);
    if (!rst_n)      exp_addr = 0;
    else if (ld)     exp_addr = (hi ? 256 : 0) + lo;
    else if (inc && rd)  exp_addr = (exp_addr + 1) % SPAN;
    else if (inc)    exp_addr = (exp_addr / PAGE) * PAGE + ((exp_addr + 1) % PAGE);
    #1;
    compared++;
    if (int'(addr_o) !== exp_addr) begin
      mismatched++;
      $display("FAIL %s: addr_o=0x%03h expected 0x%03h", tag, addr_o, exp_addr);
    end
    @(negedge clk);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    mismatched++;
    $display("FAIL watchdog: cycles=%0d expected end before %0d", cycles, 100000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    load_i = 0; load_hi_i = 0; load_lo_i = 0; inc_i = 0; inc_rd_i = 0;
    @(negedge clk);
    // R1: reset ignores strobes and keeps address 0
    step(1, 1, 8'h55, 0, 0, "R1");
    step(0, 0, 8'h00, 1, 1, "R1");
    step(0, 0, 8'h00, 0, 0, "R1");
    rst_n = 1'b1;
    step(0, 0, 8'h00, 0, 0, "R1");
    // R2: load both halves
    step(1, 1, 8'hAC, 0, 0, "R2");
    step(1, 0, 8'h35, 0, 0, "R2");
    // R3: write burst wraps inside page 0x1A0
    step(1, 1, 8'hA7, 0, 0, "R2");
    for (int i = 0; i < 20; i++) step(0, 0, 8'h00, 1, 0, "R3");
    // R3: last page, offset 15 wraps to 0x1F0
    step(1, 1, 8'hFF, 0, 0, "R2");
    step(0, 0, 8'h00, 1, 0, "R3");
    // R5: hold between transactions, then a read continues
    for (int i = 0; i < 6; i++) step(0, 1, 8'hEE, 0, 1, "R5");
    step(0, 0, 8'h00, 1, 1, "R5");
    // R4: read crosses page and half boundary
    step(1, 0, 8'hFD, 0, 0, "R2");
    for (int i = 0; i < 5; i++) step(0, 0, 8'h00, 1, 1, "R4");
    // R4: top of array wraps to zero
    step(1, 1, 8'hFE, 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 8'h00, 1, 1, "R4");
    // R6: load beats a simultaneous step of either kind
    step(1, 1, 8'h4F, 1, 0, "R6");
    step(1, 0, 8'hFF, 1, 1, "R6");
    // R7: load then steps on consecutive cycles
    step(1, 1, 8'h0E, 0, 0, "R7");
    step(0, 0, 8'h00, 1, 0, "R7");
    step(0, 0, 8'h00, 1, 1, "R7");
    step(0, 0, 8'h00, 1, 0, "R7");
    // Mixed random traffic over all requirements
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      step(r == 0, 1'($urandom), 8'($urandom), r > 3, 1'($urandom), "R2/R3/R4/R5 mix");
    end
    // R1: reset in mid-run
    rst_n = 1'b0;
    step(0, 0, 8'h00, 1, 1, "R1");
    rst_n = 1'b1;
    step(0, 0, 8'h00, 0, 0, "R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule